// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This core executes one 32-bit instruction per clock. The program counter drives the instruction port. The returned word is split into one of three fixed layouts: register, immediate or jump. The core then reads two operands from a 32-entry register file, computes a result in a small ALU, optionally reads or writes the data port, and writes one result back. All of this happens in the same cycle. At the next rising edge the program counter takes its new value: the sequential address, a PC-relative branch target, a region-relative jump target or a register value.

The supported operations are register add, subtract and signed set-less-than. The immediate forms are add, signed set-less-than, OR and load-upper. The core also has word load and store, branch on equal and not-equal, jump, jump-with-link and jump through a register. Any other encoding is treated as a no-op and raises a flag for that cycle.

The core has no state machine beyond the program counter. The only choice made each cycle is which next-address path to take. That choice is an enumerated kind with five values:
- sequential (the default for every non-control instruction, including unrecognised ones)
- branch-if-equal
- branch-if-not-equal
- absolute jump
- register jump

Each value maps to exactly one transition of the program counter.

Top module: `sc_core`

## Requirements
- R1: While reset is low, the instruction address is 0x00400000, the data read and write strobes and the illegal flag are low, and every register holds zero. The first instruction fetched after reset leaves is at 0x00400000.
- R2: Instruction bits [31:26] hold the opcode. Register layout: source A in [25:21], source B in [20:16], destination in [15:11], shift field in [10:6], function code in [5:0]. Opcode 0 with function 32 writes A+B to the destination; function 34 writes A−B.
- R3: Opcode 0 with function 42 writes 1 to the destination when A < B as signed values, and 0 otherwise. Opcode 8 (add-immediate) and opcode 10 (set-less-than-immediate) sign-extend bits [15:0] and write the field in [20:16].
- R4: Opcode 13 ORs register A with the zero-extended immediate. Opcode 15 writes the immediate to bits [31:16] with zeros below. Both write the field in [20:16].
- R5: Register 0 always reads as zero. Writes that target it are discarded.
- R6: Opcode 35 loads the data word at A + sign-extended immediate into register [20:16]. Opcode 43 drives that address with the write strobe high and register [20:16] as write data. The strobe is valid in the same cycle the instruction is presented.
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare A and B. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate shifted left by two; otherwise it is PC+4.
- R8: Opcode 2 jumps to {PC+4[31:28], bits[25:0], 2'b00}. Opcode 3 does the same and also writes PC+4 into register 31.
- R9: Opcode 0 with function 8 loads the PC from register A.
- R10: An opcode outside the supported set, an unlisted function code, or a non-zero shift field under opcode 0 raises the illegal flag for that cycle. Such an instruction writes no register, issues no data strobe, and the PC advances by 4.
- R11: Outside control transfers, the instruction address advances by exactly 4 on each rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory on the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |
| illegal | output | 1 | High while an unsupported encoding is presented |

## Verification
The data strobes, address and illegal flag depend combinationally on the presented instruction, so they are due in the same cycle that instruction sits on the port. Register results and the new program counter appear one rising edge later. The bench changes inputs and samples only on falling edges. That gives half a period after each edge for the combinational outputs to settle. Per-instruction timing is checked by counting falling edges after reset release: PC advance, jump landing, load strobe and illegal flag. Architectural results are read back through stores once the program has reached its closing self-jump.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int DW      = 32;
    localparam int OPW     = 6;
    localparam int RIW     = 5;
    localparam int IMMW    = 16;
    localparam int JAW     = 26;

    localparam logic [OPW-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OPC_J     = 6'd2;
    localparam logic [OPW-1:0] OPC_JAL   = 6'd3;
    localparam logic [OPW-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPW-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPW-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPW-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPW-1:0] OPC_LUI   = 6'd15;
    localparam logic [OPW-1:0] OPC_LW    = 6'd35;
    localparam logic [OPW-1:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    localparam logic [RIW-1:0] LINK_REG = 5'd31;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_OR,
        ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_RT,
        DST_RD,
        DST_LINK
    } dst_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_MEM,
        WB_LINK
    } wb_e;

    typedef enum logic [2:0] {
        NXT_SEQ,
        NXT_BEQ,
        NXT_BNE,
        NXT_JUMP,
        NXT_REG
    } nxt_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        logic    use_imm;
        logic    zext;
        alu_op_e alu;
        logic    mem_rd;
        logic    mem_wr;
        wb_e     wb;
        nxt_e    nxt;
        logic    bad;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [5:0]     funct,
    input  logic [4:0]     shamt,
    output ctrl_t          ctrl
);

    localparam ctrl_t CTRL_NOP = '{
        reg_we:  1'b0,
        dst:     DST_RT,
        use_imm: 1'b0,
        zext:    1'b0,
        alu:     ALU_ADD,
        mem_rd:  1'b0,
        mem_wr:  1'b0,
        wb:      WB_ALU,
        nxt:     NXT_SEQ,
        bad:     1'b0
    };

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (op)
            OPC_RTYPE: begin
                if (shamt != '0) begin
                    ctrl.bad = 1'b1;
                end else begin
                    unique case (funct)
                        FN_ADD: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu    = ALU_ADD;
                        end
                        FN_SUB: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu    = ALU_SUB;
                        end
                        FN_SLT: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu    = ALU_SLT;
                        end
                        FN_JR: begin
                            ctrl.nxt = NXT_REG;
                        end
                        default: begin
                            ctrl.bad = 1'b1;
                        end
                    endcase
                end
            end
            OPC_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_ADD;
            end
            OPC_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_SLT;
            end
            OPC_ORI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.zext    = 1'b1;
                ctrl.alu     = ALU_OR;
            end
            OPC_LUI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_LUI;
            end
            OPC_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_ADD;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb      = WB_MEM;
            end
            OPC_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_ADD;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu = ALU_SUB;
                ctrl.nxt = NXT_BEQ;
            end
            OPC_BNE: begin
                ctrl.alu = ALU_SUB;
                ctrl.nxt = NXT_BNE;
            end
            OPC_J: begin
                ctrl.nxt = NXT_JUMP;
            end
            OPC_JAL: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
                ctrl.nxt    = NXT_JUMP;
            end
            default: begin
                ctrl.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq
);

    localparam int HALF = W / 2;

    logic [W-1:0] diff;

    assign diff = a - b;
    assign eq   = (diff == '0);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_OR:  y = a | b;
            ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [W-1:0]            wdata,
    input  logic [$clog2(NREG)-1:0] ra1,
    output logic [W-1:0]            rd1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [W-1:0]            rd2
);

    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(0)) |=> (regs[0] == '0))
        else $error("register 0 changed by a write");

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000,
    parameter int          NREG     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    output logic        dmem_re,
    input  logic [31:0] dmem_rdata,
    output logic        illegal
);

    localparam int SEGW = 4;

    logic [DW-1:0]   pc_q;
    logic [DW-1:0]   pc_next;
    logic [DW-1:0]   pc_plus4;
    logic [DW-1:0]   br_target;
    logic [DW-1:0]   jmp_target;

    logic [OPW-1:0]  f_op;
    logic [RIW-1:0]  f_rs;
    logic [RIW-1:0]  f_rt;
    logic [RIW-1:0]  f_rd;
    logic [4:0]      f_shamt;
    logic [5:0]      f_funct;
    logic [IMMW-1:0] f_imm;
    logic [JAW-1:0]  f_jaddr;

    ctrl_t           ctrl;
    logic [DW-1:0]   rs_val;
    logic [DW-1:0]   rt_val;
    logic [DW-1:0]   imm_ext;
    logic [DW-1:0]   alu_b;
    logic [DW-1:0]   alu_y;
    logic            alu_eq;
    logic            rf_we;
    logic [RIW-1:0]  rf_waddr;
    logic [DW-1:0]   rf_wdata;

    // instruction field split
    assign f_op    = imem_data[31:26];
    assign f_rs    = imem_data[25:21];
    assign f_rt    = imem_data[20:16];
    assign f_rd    = imem_data[15:11];
    assign f_shamt = imem_data[10:6];
    assign f_funct = imem_data[5:0];
    assign f_imm   = imem_data[15:0];
    assign f_jaddr = imem_data[25:0];

    sc_decode u_dec (
        .op    (f_op),
        .funct (f_funct),
        .shamt (f_shamt),
        .ctrl  (ctrl)
    );

    sc_regfile #(
        .NREG (NREG),
        .W    (DW)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra1   (f_rs),
        .rd1   (rs_val),
        .ra2   (f_rt),
        .rd2   (rt_val)
    );

    assign imm_ext = ctrl.zext ? {{(DW-IMMW){1'b0}}, f_imm}
                               : {{(DW-IMMW){f_imm[IMMW-1]}}, f_imm};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(
        .W (DW)
    ) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu),
        .y  (alu_y),
        .eq (alu_eq)
    );

    // write-back destination and data
    always_comb begin
        unique case (ctrl.dst)
            DST_RT:   rf_waddr = f_rt;
            DST_RD:   rf_waddr = f_rd;
            DST_LINK: rf_waddr = LINK_REG;
            default:  rf_waddr = f_rt;
        endcase
    end

    always_comb begin
        unique case (ctrl.wb)
            WB_ALU:  rf_wdata = alu_y;
            WB_MEM:  rf_wdata = dmem_rdata;
            WB_LINK: rf_wdata = pc_plus4;
            default: rf_wdata = alu_y;
        endcase
    end

    assign rf_we = ctrl.reg_we && rst_n;

    // next-address selection
    assign pc_plus4   = pc_q + DW'(4);
    assign br_target  = pc_plus4 + {imm_ext[DW-3:0], 2'b00};
    assign jmp_target = {pc_plus4[DW-1:DW-SEGW], f_jaddr, 2'b00};

    always_comb begin
        unique case (ctrl.nxt)
            NXT_SEQ:  pc_next = pc_plus4;
            NXT_BEQ:  pc_next = alu_eq ? br_target : pc_plus4;
            NXT_BNE:  pc_next = alu_eq ? pc_plus4 : br_target;
            NXT_JUMP: pc_next = jmp_target;
            NXT_REG:  pc_next = rs_val;
            default:  pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    // port outputs
    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr && rst_n;
    assign dmem_re    = ctrl.mem_rd && rst_n;
    assign illegal    = ctrl.bad && rst_n;

    // checks next to the logic they guard
    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imem_addr == RESET_PC))
        else $error("first fetch after reset not at reset address");

    assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nxt == NXT_SEQ) |=> (imem_addr == $past(imem_addr) + 32'd4))
        else $error("sequential step not +4");

    assert_beq_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nxt == NXT_BEQ && rs_val == rt_val) |=>
        (imem_addr == $past(imem_addr) + 32'd4 +
            {{14{$past(f_imm[15])}}, $past(f_imm), 2'b00}))
        else $error("taken branch landed at wrong address");

    assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op == OPC_JAL) |->
        (rf_we && rf_waddr == 5'd31 && rf_wdata == imem_addr + 32'd4))
        else $error("link write wrong");

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!dmem_we && !dmem_re && !rf_we))
        else $error("illegal encoding had a side effect");

endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic        dmem_re;
    logic [31:0] dmem_rdata;
    logic        illegal;

    logic [31:0] imem [0:63];
    logic [31:0] dmem [0:63];

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sc_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata),
        .illegal    (illegal)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // encoders following the field layout of R2 and R8
    function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] rr(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] rj(input logic [5:0] op, input int word);
        return {op, 26'h100000 + 26'(word)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic setup();
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = rj(6'd2, i);
            dmem[i] = 32'hA5A5_A5A5;
        end
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
    endtask

    task automatic t_reset();
        setup();
        dmem[0] = 32'h0000_DEAD;
        dmem[1] = 32'h0000_BEEF;
        imem[0] = ri(6'd43, 5'd0, 5'd5, 16'd0);
        imem[1] = ri(6'd43, 5'd0, 5'd31, 16'd4);
        imem[2] = rj(6'd2, 2);
        @(negedge clk);
        chk("R1", "addr in reset", imem_addr, 32'h0040_0000);
        chk("R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
        chk("R1", "load strobe in reset", {31'd0, dmem_re}, 32'd0);
        chk("R1", "illegal in reset", {31'd0, illegal}, 32'd0);
        release_reset();
        chk("R1", "first fetch", imem_addr, 32'h0040_0000);
        @(negedge clk);
        chk("R11", "second fetch", imem_addr, 32'h0040_0004);
        @(negedge clk);
        chk("R11", "third fetch", imem_addr, 32'h0040_0008);
        repeat (5) @(negedge clk);
        chk("R1", "r5 zero after reset", dmem[0], 32'd0);
        chk("R1", "r31 zero after reset", dmem[1], 32'd0);
    endtask

    task automatic t_arith();
        setup();
        imem[0]  = ri(6'd8, 5'd0, 5'd8, 16'd5);
        imem[1]  = ri(6'd8, 5'd0, 5'd9, 16'hFFFD);
        imem[2]  = rr(5'd8, 5'd9, 5'd10, 6'd32);
        imem[3]  = rr(5'd8, 5'd9, 5'd11, 6'd34);
        imem[4]  = rr(5'd9, 5'd8, 5'd12, 6'd42);
        imem[5]  = rr(5'd8, 5'd9, 5'd13, 6'd42);
        imem[6]  = ri(6'd10, 5'd9, 5'd14, 16'd0);
        imem[7]  = ri(6'd8, 5'd0, 5'd0, 16'd7);
        imem[8]  = ri(6'd43, 5'd0, 5'd10, 16'd0);
        imem[9]  = ri(6'd43, 5'd0, 5'd11, 16'd4);
        imem[10] = ri(6'd43, 5'd0, 5'd12, 16'd8);
        imem[11] = ri(6'd43, 5'd0, 5'd13, 16'd12);
        imem[12] = ri(6'd43, 5'd0, 5'd14, 16'd16);
        imem[13] = ri(6'd43, 5'd0, 5'd0, 16'd20);
        imem[14] = rr(5'd9, 5'd8, 5'd15, 6'd34);
        imem[15] = ri(6'd43, 5'd0, 5'd15, 16'd24);
        imem[16] = rj(6'd2, 16);
        release_reset();
        repeat (40) @(negedge clk);
        chk("R2", "add 5+(-3)", dmem[0], 32'd2);
        chk("R2", "sub 5-(-3)", dmem[1], 32'd8);
        chk("R3", "slt -3<5", dmem[2], 32'd1);
        chk("R3", "slt 5<-3", dmem[3], 32'd0);
        chk("R3", "slti -3<0", dmem[4], 32'd1);
        chk("R5", "r0 after write", dmem[5], 32'd0);
        chk("R2", "sub -3-5", dmem[6], 32'hFFFF_FFF8);
    endtask

    task automatic t_logic();
        setup();
        imem[0] = ri(6'd15, 5'd0, 5'd8, 16'hF0F0);
        imem[1] = ri(6'd13, 5'd8, 5'd8, 16'hFF00);
        imem[2] = ri(6'd13, 5'd0, 5'd9, 16'h8000);
        imem[3] = ri(6'd15, 5'd0, 5'd10, 16'h8001);
        imem[4] = ri(6'd43, 5'd0, 5'd8, 16'd32);
        imem[5] = ri(6'd43, 5'd0, 5'd9, 16'd36);
        imem[6] = ri(6'd43, 5'd0, 5'd10, 16'd40);
        imem[7] = rj(6'd2, 7);
        release_reset();
        repeat (20) @(negedge clk);
        chk("R4", "upper then or", dmem[8], 32'hF0F0_FF00);
        chk("R4", "or zero-extends", dmem[9], 32'h0000_8000);
        chk("R4", "upper fills zeros", dmem[10], 32'h8001_0000);
    endtask

    task automatic t_load();
        setup();
        dmem[10] = 32'h1234_5678;
        imem[0] = ri(6'd35, 5'd0, 5'd8, 16'd40);
        imem[1] = ri(6'd8, 5'd8, 5'd8, 16'd1);
        imem[2] = ri(6'd43, 5'd0, 5'd8, 16'd44);
        imem[3] = ri(6'd8, 5'd0, 5'd9, 16'd48);
        imem[4] = ri(6'd35, 5'd9, 5'd10, 16'hFFF8);
        imem[5] = ri(6'd43, 5'd9, 5'd10, 16'd4);
        imem[6] = rj(6'd2, 6);
        release_reset();
        chk("R6", "load strobe same cycle", {31'd0, dmem_re}, 32'd1);
        chk("R6", "load address", dmem_addr, 32'd40);
        repeat (20) @(negedge clk);
        chk("R6", "load then add", dmem[11], 32'h1234_5679);
        chk("R6", "negative offset load", dmem[13], 32'h1234_5678);
    endtask

    task automatic t_branch();
        setup();
        imem[0]  = ri(6'd8, 5'd0, 5'd8, 16'd1);
        imem[1]  = ri(6'd8, 5'd0, 5'd9, 16'd0);
        imem[2]  = ri(6'd4, 5'd8, 5'd8, 16'd1);
        imem[3]  = ri(6'd8, 5'd0, 5'd9, 16'd99);
        imem[4]  = ri(6'd43, 5'd0, 5'd9, 16'd64);
        imem[5]  = ri(6'd8, 5'd0, 5'd10, 16'd0);
        imem[6]  = ri(6'd5, 5'd8, 5'd8, 16'd1);
        imem[7]  = ri(6'd8, 5'd0, 5'd10, 16'd7);
        imem[8]  = ri(6'd43, 5'd0, 5'd10, 16'd68);
        imem[9]  = ri(6'd8, 5'd0, 5'd11, 16'd0);
        imem[10] = ri(6'd8, 5'd0, 5'd12, 16'd3);
        imem[11] = ri(6'd8, 5'd11, 5'd11, 16'd1);
        imem[12] = ri(6'd5, 5'd11, 5'd12, 16'hFFFE);
        imem[13] = ri(6'd43, 5'd0, 5'd11, 16'd72);
        imem[14] = rj(6'd2, 14);
        release_reset();
        repeat (40) @(negedge clk);
        chk("R7", "equal branch skipped", dmem[16], 32'd0);
        chk("R7", "not-equal fell through", dmem[17], 32'd7);
        chk("R7", "backward loop count", dmem[18], 32'd3);
    endtask

    task automatic t_jump();
        setup();
        imem[0] = ri(6'd8, 5'd0, 5'd8, 16'd1);
        imem[1] = rj(6'd2, 3);
        imem[2] = ri(6'd8, 5'd0, 5'd8, 16'd99);
        imem[3] = rj(6'd3, 6);
        imem[4] = ri(6'd43, 5'd0, 5'd8, 16'd52);
        imem[5] = rj(6'd2, 5);
        imem[6] = ri(6'd43, 5'd0, 5'd31, 16'd56);
        imem[7] = rr(5'd31, 5'd0, 5'd0, 6'd8);
        release_reset();
        @(negedge clk);
        @(negedge clk);
        chk("R8", "jump landing", imem_addr, 32'h0040_000C);
        repeat (20) @(negedge clk);
        chk("R8", "skipped word not run", dmem[13], 32'd1);
        chk("R8", "link value", dmem[14], 32'h0040_0010);
        chk("R9", "register jump return", imem_addr, 32'h0040_0014);
    endtask

    task automatic t_illegal();
        setup();
        imem[0] = ri(6'd8, 5'd0, 5'd8, 16'd5);
        imem[1] = ri(6'd63, 5'd0, 5'd8, 16'h0040);
        imem[2] = rr(5'd0, 5'd0, 5'd8, 6'h3F);
        imem[3] = {6'd0, 5'd0, 5'd0, 5'd8, 5'd3, 6'd32};
        imem[4] = ri(6'd43, 5'd0, 5'd8, 16'd80);
        imem[5] = rj(6'd2, 5);
        release_reset();
        chk("R10", "flag low on legal word", {31'd0, illegal}, 32'd0);
        @(negedge clk);
        chk("R10", "flag on bad opcode", {31'd0, illegal}, 32'd1);
        chk("R10", "no store on bad opcode", {31'd0, dmem_we}, 32'd0);
        @(negedge clk);
        chk("R10", "flag on bad function", {31'd0, illegal}, 32'd1);
        @(negedge clk);
        chk("R10", "flag on nonzero shift", {31'd0, illegal}, 32'd1);
        chk("R10", "pc stepped by 4", imem_addr, 32'h0040_000C);
        repeat (10) @(negedge clk);
        chk("R10", "register untouched", dmem[20], 32'd5);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_load();
        t_branch();
        t_jump();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule